// File: doc/BRIEF.md
# Driver Fault Supervisor

This block sits between the programmed switch commands of a six-output half-bridge driver and the gate drive of its twelve switches. It receives raw fault flags from analog comparators: an overcurrent flag and an open-load or underload flag for every switch, and chip-wide flags for supply undervoltage, supply overvoltage, temperature prewarning and thermal shutdown. From these it decides which switch enables reach the power stage. It also assembles the latched diagnosis word that the serial interface shifts out.

A per-switch fault must persist for a qualification time before it acts. The time is counted in pulses of a slow `tick` input. A qualified per-switch fault turns off only the switch that failed. Thermal shutdown and undervoltage turn off every switch. Overvoltage also turns off every switch unless its protection is masked. Overcurrent and open-load shutdown each have their own enable bit.

Supply faults never alter the command inputs. When the supply recovers, the outputs return to the programmed pattern on their own. The sticky diagnosis bits and the per-switch trips are cleared by a status-reset pulse. A command rewrite (`cmd_we`) releases the trips but keeps the diagnosis bits.

Top module: `drv_fault_guard`

## Requirements
- R1: After reset no switch is tripped and diagnosis bits 13, 14 and 15 are 0. Each enable then equals its command whenever no chip-wide fault is present.
- R2: A switch flag on `oc_hs`/`oc_ls` or `ol_hs`/`ol_ls` qualifies only after it has stayed high through OC_TICKS (overcurrent) or OL_TICKS (open load) consecutive `tick` pulses. If the flag drops before that count is reached, the count starts again from zero.
- R3: A qualified overcurrent sets diagnosis bit 13. When `oc_en` is 1, it also turns off only the affected switch. When `oc_en` is 0, no switch is turned off.
- R4: A qualified open-load flag sets diagnosis bit 14. When `ol_en` is 1, it also turns off only the affected switch. When `ol_en` is 0, no switch is turned off.
- R5: While `tsd` or `uv` is high, every enable is 0.
- R6: While `ov` is high and `ov_en` is 1, every enable is 0. With `ov_en` at 0, `ov` changes no enable. A high `uv` or `ov` sets diagnosis bit 15 at the next clock edge.
- R7: When the supply and thermal flags fall, the enables return to the command pattern without any rewrite of the commands.
- R8: Diagnosis bit 0 follows `tpw` directly, and `tpw` changes no enable.
- R9: A tripped switch stays off, and its sticky bit stays set, after its flag drops. `clr_stat` clears the trips and bits 13 to 15. `cmd_we` clears the trips only.
- R10: Diagnosis bits 1 to 12 show the actual enables: bit 2k-1 is the low-side switch of output k and bit 2k is the high-side switch of output k, for k = 1..6. Port vector index k-1 is output k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Qualification time base pulse |
| cmd_hs | input | 6 | Programmed high-side commands |
| cmd_ls | input | 6 | Programmed low-side commands |
| cmd_we | input | 1 | Pulse: commands rewritten, release trips |
| oc_en | input | 1 | Overcurrent shutdown enable |
| ol_en | input | 1 | Open-load shutdown enable |
| ov_en | input | 1 | Overvoltage shutdown enable |
| clr_stat | input | 1 | Pulse: clear trips and sticky bits |
| oc_hs | input | 6 | High-side overcurrent flags |
| oc_ls | input | 6 | Low-side overcurrent flags |
| ol_hs | input | 6 | High-side open-load flags |
| ol_ls | input | 6 | Low-side open-load flags |
| uv | input | 1 | Supply undervoltage |
| ov | input | 1 | Supply overvoltage |
| tpw | input | 1 | Temperature prewarning |
| tsd | input | 1 | Thermal shutdown |
| en_hs | output | 6 | High-side switch enables |
| en_ls | output | 6 | Low-side switch enables |
| diag | output | 16 | Diagnosis word |

## Verification
A qualification counter that runs off by one shows up as a switch turning off one tick early or late. That difference appears in the enable and in bit 13 or 14 on the clock edge after the deciding tick. A trip latch on the wrong switch, or a bit swap in the diagnosis word, shows up at once as a wrong bit in the enable pattern. A sticky bit that fails to hold shows up on the first cycle after its flag falls. A chip-wide fault that fails to release shows up on the first cycle after recovery, when the enables stay low.

// File: rtl/drv_fault_guard.sv
module drv_fault_guard #(
  parameter int N_OUT    = 6,
  parameter int OC_TICKS = 3,
  parameter int OL_TICKS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N_OUT-1:0]   cmd_hs,
  input  logic [N_OUT-1:0]   cmd_ls,
  input  logic               cmd_we,
  input  logic               oc_en,
  input  logic               ol_en,
  input  logic               ov_en,
  input  logic               clr_stat,
  input  logic [N_OUT-1:0]   oc_hs,
  input  logic [N_OUT-1:0]   oc_ls,
  input  logic [N_OUT-1:0]   ol_hs,
  input  logic [N_OUT-1:0]   ol_ls,
  input  logic               uv,
  input  logic               ov,
  input  logic               tpw,
  input  logic               tsd,
  output logic [N_OUT-1:0]   en_hs,
  output logic [N_OUT-1:0]   en_ls,
  output logic [2*N_OUT+3:0] diag
);
  localparam int NSW = 2 * N_OUT;
  localparam int OCW = $clog2(OC_TICKS + 1);
  localparam int OLW = $clog2(OL_TICKS + 1);

  logic [NSW-1:0] cmd_sw, oc_sw, ol_sw, oc_q, ol_q, trip, en_sw;
  logic st_sup, st_ol, st_oc, kill_all;

  for (genvar k = 0; k < N_OUT; k++) begin : g_map
    assign cmd_sw[2*k]   = cmd_ls[k];
    assign cmd_sw[2*k+1] = cmd_hs[k];
    assign oc_sw[2*k]    = oc_ls[k];
    assign oc_sw[2*k+1]  = oc_hs[k];
    assign ol_sw[2*k]    = ol_ls[k];
    assign ol_sw[2*k+1]  = ol_hs[k];
    assign en_ls[k]      = en_sw[2*k];
    assign en_hs[k]      = en_sw[2*k+1];
  end

  for (genvar j = 0; j < NSW; j++) begin : g_qual
    logic [OCW-1:0] oc_cnt;
    logic [OLW-1:0] ol_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  oc_cnt <= '0;
      else if (!oc_sw[j])                          oc_cnt <= '0;
      else if (tick && oc_cnt != OCW'(OC_TICKS))   oc_cnt <= oc_cnt + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ol_cnt <= '0;
      else if (!ol_sw[j])                          ol_cnt <= '0;
      else if (tick && ol_cnt != OLW'(OL_TICKS))   ol_cnt <= ol_cnt + 1'b1;
    end
    assign oc_q[j] = oc_sw[j] && (oc_cnt == OCW'(OC_TICKS));
    assign ol_q[j] = ol_sw[j] && (ol_cnt == OLW'(OL_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip   <= '0;
      st_oc  <= 1'b0;
      st_ol  <= 1'b0;
      st_sup <= 1'b0;
    end else begin
      trip   <= ((clr_stat || cmd_we) ? '0 : trip)
                | (oc_q & {NSW{oc_en}}) | (ol_q & {NSW{ol_en}});
      st_oc  <= (clr_stat ? 1'b0 : st_oc)  | (|oc_q);
      st_ol  <= (clr_stat ? 1'b0 : st_ol)  | (|ol_q);
      st_sup <= (clr_stat ? 1'b0 : st_sup) | uv | ov;
    end
  end

  assign kill_all = tsd | uv | (ov & ov_en);
  assign en_sw    = kill_all ? '0 : (cmd_sw & ~trip);
  assign diag     = {st_sup, st_ol, st_oc, en_sw, tpw};

  AST_THERMAL_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd || uv) |-> (en_hs == '0 && en_ls == '0)); // R5
  AST_OV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && ov_en) |-> (en_hs == '0 && en_ls == '0)); // R6
  AST_SUPPLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (uv || ov) |=> diag[NSW+3]); // R6
  AST_NO_UNCOMMANDED: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_hs & ~cmd_hs) == '0 && (en_ls & ~cmd_ls) == '0)); // R10
  AST_TRIP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (trip != '0) |-> (diag[NSW+1] || diag[NSW+2])); // R9
  AST_CLR_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !uv && !ov) |=> !diag[NSW+3]); // R9
endmodule

// File: tb/drv_fault_guard_test.sv
module drv_fault_guard_test;
  localparam int N = 6, NSW = 12, OCT = 3, OLT = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tick = 0, cmd_we = 0, oc_en = 0, ol_en = 0, ov_en = 0, clr_stat = 0;
  logic uv = 0, ov = 0, tpw = 0, tsd = 0;
  logic [NSW-1:0] cmd_v = '0, oc_v = '0, ol_v = '0, en_v;
  logic [N-1:0] cmd_hs, cmd_ls, oc_hs, oc_ls, ol_hs, ol_ls, en_hs, en_ls;
  logic [15:0] diag;

  for (genvar k = 0; k < N; k++) begin : g_b
    assign cmd_ls[k] = cmd_v[2*k];  assign cmd_hs[k] = cmd_v[2*k+1];
    assign oc_ls[k]  = oc_v[2*k];   assign oc_hs[k]  = oc_v[2*k+1];
    assign ol_ls[k]  = ol_v[2*k];   assign ol_hs[k]  = ol_v[2*k+1];
    assign en_v[2*k] = en_ls[k];    assign en_v[2*k+1] = en_hs[k];
  end

  drv_fault_guard #(.N_OUT(N), .OC_TICKS(OCT), .OL_TICKS(OLT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_hs(cmd_hs), .cmd_ls(cmd_ls),
    .cmd_we(cmd_we), .oc_en(oc_en), .ol_en(ol_en), .ov_en(ov_en), .clr_stat(clr_stat),
    .oc_hs(oc_hs), .oc_ls(oc_ls), .ol_hs(ol_hs), .ol_ls(ol_ls),
    .uv(uv), .ov(ov), .tpw(tpw), .tsd(tsd), .en_hs(en_hs), .en_ls(en_ls), .diag(diag));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin tick = 1; step(); tick = 0; end
  endtask

  task automatic pulse_clr();
    clr_stat = 1; step(); clr_stat = 0;
  endtask

  function automatic logic [15:0] mk(logic [11:0] en, logic s15, logic s14, logic s13, logic t);
    return {s15, s14, s13, en, t};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_cmp++;
    if (diag !== exp || en_v !== exp[12:1]) begin
      n_bad++;
      $display("FAIL %s: actual diag %h en %h expected diag %h", req, diag, en_v, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cmd_v = 12'h5A3;
    step(); step();
    check("R1 in reset", mk(12'h5A3, 0, 0, 0, 0));
    rst_n = 1; step();
    check("R1 after reset", mk(12'h5A3, 0, 0, 0, 0));

    // R2 R3: overcurrent sweep over every switch, enable on and off
    for (int e = 0; e < 2; e++) begin
      for (int j = 0; j < NSW; j++) begin
        logic [11:0] one, expen;
        one = 12'(1) << j;
        cmd_v = '1; oc_en = e[0]; ol_en = 1;
        pulse_clr();
        oc_v = one; tick_n(OCT - 1); step();
        check("R2 below limit", mk('1, 0, 0, 0, 0));
        oc_v = '0; step(); oc_v = one; tick_n(OCT - 1); step();
        check("R2 restart", mk('1, 0, 0, 0, 0));
        tick_n(1); step();
        expen = e[0] ? ~one : '1;
        check("R3 trip", mk(expen, 0, 0, 1, 0));
        oc_v = '0; step(); step();
        check("R9 latched", mk(expen, 0, 0, 1, 0));
        pulse_clr();
        check("R9 clear", mk('1, 0, 0, 0, 0));
      end
    end
    oc_en = 0;

    // R4 R9: open-load sweep, release by command rewrite
    for (int e = 0; e < 2; e++) begin
      for (int j = 0; j < NSW; j++) begin
        logic [11:0] one, expen;
        one = 12'(1) << j;
        cmd_v = '1; ol_en = e[0];
        pulse_clr();
        ol_v = one; tick_n(OLT - 1); step();
        check("R4 below limit", mk('1, 0, 0, 0, 0));
        tick_n(1); step();
        expen = e[0] ? ~one : '1;
        check("R4 trip", mk(expen, 0, 1, 0, 0));
        ol_v = '0; step();
        check("R9 ol latched", mk(expen, 0, 1, 0, 0));
        cmd_we = 1; step(); cmd_we = 0;
        check("R9 rewrite keeps bit", mk('1, 0, 1, 0, 0));
        pulse_clr();
        check("R9 ol clear", mk('1, 0, 0, 0, 0));
      end
    end

    // R5 R6 R7 R8: every combination of chip-wide flags and the overvoltage mask
    for (int m = 0; m < 32; m++) begin
      logic [11:0] c;
      logic kill;
      c = 12'(m * 37 + 5);
      cmd_v = c;
      pulse_clr();
      tsd = m[0]; uv = m[1]; ov = m[2]; ov_en = m[3]; tpw = m[4];
      step();
      kill = tsd | uv | (ov & ov_en);
      check("R5 R6 R8 global", mk(kill ? 12'h0 : c, uv | ov, 0, 0, tpw));
      tsd = 0; uv = 0; ov = 0; tpw = 0;
      step();
      check("R7 resume", mk(c, m[1] | m[2], 0, 0, 0));
    end
    pulse_clr();
    check("R10 final layout", mk(12'(31 * 37 + 5), 0, 0, 0, 0));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule